// File: doc/BRIEF.md
# Four-bit carry lookahead adder

This block adds two 4-bit unsigned operands and a carry-in. It returns a 4-bit sum and a carry-out, and it has no clock. Every bit position forms a generate term (both operand bits set) and a propagate term. Each carry into a higher position, the carry-out included, comes from its own flat two-level sum of products over those terms and the carry-in. No carry waits on the carry of the bit below it, so the carry path stays at two gate levels for any bit.

A parameter selects how the propagate term is formed. It is either the OR or the XOR of the two operand bits. The sum always uses the XOR half-sum, so both choices give the same arithmetic result. The block also drives a group generate and a group propagate. A larger adder can use these to treat the four bits as one lookahead digit.

Top module: `cla4_adder`

## Requirements
- R1: When bit i of both operands is 1, the carry into position i+1 is 1 for any carry-in and any lower bits. For example, a = b = 2^i with carry-in 0 gives a sum of 2^(i+1) mod 16.
- R2: The propagate variant changes nothing at the outputs. With parameter PROP_MODE = PROP_OR the propagate term is a|b. With PROP_XOR it is a^b. Both variants give the same sum_o and c_o for every input.
- R3: sum_o equals (a_i + b_i + c_i) mod 16 for all 512 input combinations.
- R4: c_o equals bit 4 of a_i + b_i + c_i. In particular, a = 4'hF and b = 4'h0 give c_o = c_i.
- R5: grp_gen_o is 1 exactly when a_i + b_i >= 16, in both variants.
- R6: grp_prop_o is 1 exactly when every per-bit propagate term is 1. That means a_i|b_i = 4'hF in the OR variant and a_i^b_i = 4'hF in the XOR variant. In both variants c_o = grp_gen_o | (grp_prop_o & c_i).
- R7: c_i has no effect on grp_gen_o or grp_prop_o.
- R8: In the XOR variant, no bit has its generate and propagate terms both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 4 | Sum bits |
| c_o | output | 1 | Carry out of bit 3 |
| grp_gen_o | output | 1 | The four bits generate a carry on their own |
| grp_prop_o | output | 1 | The four bits pass an incoming carry through |

## Verification
The bench walks all 512 combinations of both operands and the carry-in, and it does so for both propagate variants side by side. This covers every mix of generate, propagate and kill across the positions, including the long carry run from carry-in to carry-out. Comparing the two variants shows whether the sum wrongly depends on how propagate is formed. Pairing each operand pair under both carry-in values shows whether the group outputs leak the carry-in. Single-bit operand pairs on their own show that a generate at each position reaches the next carry.

// File: rtl/cla_pkg.sv
package cla_pkg;
    typedef enum logic {
        PROP_OR  = 1'b0,
        PROP_XOR = 1'b1
    } prop_mode_e;

    localparam int unsigned CLA_WIDTH = 4;
endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell
    import cla_pkg::*;
#(
    parameter int unsigned W = CLA_WIDTH,
    parameter prop_mode_e PROP_MODE = PROP_OR
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o,
    output logic [W-1:0] half_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen_o[i]  = x_i[i] & y_i[i];
        assign half_o[i] = x_i[i] ^ y_i[i];
        if (PROP_MODE == PROP_XOR) begin : g_xor
            assign prop_o[i] = half_o[i];
            always_comb begin
                // R8: an XOR propagate cannot coexist with a generate
                assert_gen_prop_excl_R8: assert (!(gen_o[i] && prop_o[i]));
            end
        end else begin : g_or
            assign prop_o[i] = x_i[i] | y_i[i];
        end
    end
endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net
    import cla_pkg::*;
#(
    parameter int unsigned W = CLA_WIDTH
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         cin_i,
    output logic [W:0]   carry_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    assign carry_o[0] = cin_i;

    // Each carry is a flat OR of AND terms; no carry feeds another.
    for (genvar i = 0; i < W; i++) begin : g_carry
        logic [i+1:0] term_d;
        always_comb begin
            for (int j = 0; j <= i; j++) begin
                term_d[j] = gen_i[j];
                for (int k = j + 1; k <= i; k++) begin
                    term_d[j] = term_d[j] & prop_i[k];
                end
            end
            term_d[i+1] = cin_i;
            for (int k = 0; k <= i; k++) begin
                term_d[i+1] = term_d[i+1] & prop_i[k];
            end
        end
        assign carry_o[i+1] = |term_d;

        always_comb begin
            // R3: the flat form agrees with the bit-serial recurrence
            assert_carry_recur_R3: assert (carry_o[i+1] == (gen_i[i] | (prop_i[i] & carry_o[i])));
            // R1: a generating bit always yields a carry above it
            assert_gen_carry_R1: assert (!gen_i[i] || carry_o[i+1]);
        end
    end

    logic [W-1:0] grp_term_d;
    always_comb begin
        for (int j = 0; j < W; j++) begin
            grp_term_d[j] = gen_i[j];
            for (int k = j + 1; k < W; k++) begin
                grp_term_d[j] = grp_term_d[j] & prop_i[k];
            end
        end
    end
    assign grp_gen_o  = |grp_term_d;
    assign grp_prop_o = &prop_i;
endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage
    import cla_pkg::*;
#(
    parameter int unsigned W = CLA_WIDTH
) (
    input  logic [W-1:0] half_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] sum_o
);
    for (genvar i = 0; i < W; i++) begin : g_sum
        assign sum_o[i] = half_i[i] ^ carry_i[i];
    end
endmodule

// File: rtl/cla4_adder.sv
module cla4_adder
    import cla_pkg::*;
#(
    parameter prop_mode_e PROP_MODE = PROP_OR
) (
    input  logic [3:0] a_i,
    input  logic [3:0] b_i,
    input  logic       c_i,
    output logic [3:0] sum_o,
    output logic       c_o,
    output logic       grp_gen_o,
    output logic       grp_prop_o
);
    localparam int unsigned W = CLA_WIDTH;

    logic [W-1:0] gen_w;
    logic [W-1:0] prop_w;
    logic [W-1:0] half_w;
    logic [W:0]   carry_w;

    cla_pg_cell #(.W(W), .PROP_MODE(PROP_MODE)) u_pg (
        .x_i    (a_i),
        .y_i    (b_i),
        .gen_o  (gen_w),
        .prop_o (prop_w),
        .half_o (half_w)
    );

    cla_carry_net #(.W(W)) u_carry (
        .gen_i      (gen_w),
        .prop_i     (prop_w),
        .cin_i      (c_i),
        .carry_o    (carry_w),
        .grp_gen_o  (grp_gen_o),
        .grp_prop_o (grp_prop_o)
    );

    cla_sum_stage #(.W(W)) u_sum (
        .half_i  (half_w),
        .carry_i (carry_w[W-1:0]),
        .sum_o   (sum_o)
    );

    assign c_o = carry_w[W];

    always_comb begin
        // R3, R4: port-level result matches plain addition
        assert_sum_R3: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {4'b0, c_i}));
        // R6: group terms reproduce the carry-out
        assert_group_cout_R6: assert (c_o == (grp_gen_o | (grp_prop_o & c_i)));
        // R5: group generate equals carry-out with no carry-in
        assert_group_gen_R5: assert (grp_gen_o == (({1'b0, a_i} + {1'b0, b_i}) > 5'd15));
    end
endmodule

// File: tb/cla4_adder_tb.sv
module cla4_adder_tb;
    import cla_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [3:0] a, b;
    logic       ci;
    logic [3:0] s_or, s_x;
    logic       co_or, co_x, gg_or, gg_x, gp_or, gp_x;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    cla4_adder #(.PROP_MODE(PROP_OR)) u_dut (
        .a_i(a), .b_i(b), .c_i(ci),
        .sum_o(s_or), .c_o(co_or), .grp_gen_o(gg_or), .grp_prop_o(gp_or)
    );

    cla4_adder #(.PROP_MODE(PROP_XOR)) u_dut_x (
        .a_i(a), .b_i(b), .c_i(ci),
        .sum_o(s_x), .c_o(co_x), .grp_gen_o(gg_x), .grp_prop_o(gp_x)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d ci=%0d actual=%0d expected=%0d", req, a, b, ci, act, exp);
        end
    endtask

    task automatic apply(input int av, input int bv, input int cv);
        @(posedge clk);
        a  = av[3:0];
        b  = bv[3:0];
        ci = cv[0];
        @(negedge clk);
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // idle state with all-zero inputs
        chk("R3 idle sum", s_or, 0);
        chk("R4 idle cout", co_or, 0);

        // R1: a generate at each position carries upward
        for (int i = 0; i < 4; i++) begin
            apply(1 << i, 1 << i, 0);
            chk("R1 gen sum", s_or, (2 << i) & 15);
            chk("R1 gen cout", co_or, (i == 3) ? 1 : 0);
        end

        // R4: full propagate run passes the carry-in through
        for (int c = 0; c < 2; c++) begin
            apply(15, 0, c);
            chk("R4 run cout", co_or, c);
            chk("R4 run cout xor", co_x, c);
        end

        // exhaustive sweep, both variants
        for (int av = 0; av < 16; av++) begin
            for (int bv = 0; bv < 16; bv++) begin
                int gg0, gp0, ggx0, gpx0;
                gg0 = 0; gp0 = 0; ggx0 = 0; gpx0 = 0;
                for (int c = 0; c < 2; c++) begin
                    int tot;
                    tot = av + bv + c;
                    apply(av, bv, c);
                    chk("R3 sum", s_or, tot % 16);
                    chk("R4 cout", co_or, tot / 16);
                    chk("R2 sum variant", s_x, s_or);
                    chk("R2 cout variant", co_x, co_or);
                    chk("R5 ggen", gg_or, (av + bv >= 16) ? 1 : 0);
                    chk("R5 ggen xor", gg_x, (av + bv >= 16) ? 1 : 0);
                    chk("R6 gprop or", gp_or, ((av | bv) == 15) ? 1 : 0);
                    chk("R6 gprop xor", gp_x, ((av ^ bv) == 15) ? 1 : 0);
                    chk("R6 group cout", co_x, gg_x | (gp_x & c));
                    if (c == 0) begin
                        gg0 = gg_or; gp0 = gp_or; ggx0 = gg_x; gpx0 = gp_x;
                    end else begin
                        chk("R7 ggen cin", gg_or, gg0);
                        chk("R7 gprop cin", gp_or, gp0);
                        chk("R7 ggen cin xor", gg_x, ggx0);
                        chk("R7 gprop cin xor", gp_x, gpx0);
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule